// File: doc/BRIEF.md
# Debug Channel Interrupt Enable Register

This block holds the two enable bits that decide whether the debug mailbox status raises a processor interrupt. One enable watches the receive side and requests service while the inbound mailbox holds a word. The other watches the transmit side and requests service while the outbound mailbox has a free slot, meaning its full flag is low. The two requests are combined into a single level interrupt. The interrupt is registered, so it changes one clock after a flag or an enable changes.

Software reaches the register through a plain single-cycle system-register port. Every access presents a five-field coprocessor encoding, the current privilege level, and a grant bit from a separate access checker. Only a matching encoding, a privileged level and a granted access can read or write the register. A separate checker handles the trap and privilege rules, so there is no ready signal and no back-pressure. An access completes in the cycle it is presented. Read data is returned combinationally in that same cycle.

Two legacy per-direction lines pass the raw mailbox flags straight through. Neither enable affects them.

Top module: `dcc_irq_ctrl`

## Requirements
- R1: After reset both enable bits are 0, the interrupt output is 0, and a granted read returns 0x00000000.
- R2: An access is selected only when `acc_valid` is 1 and all five fields match: coprocessor 4'b1110, first opcode 3'b000, primary register 4'b0000, secondary register 4'b0010, second opcode 3'b000. A selected, granted write from a privileged level latches write-data bit 30 as the receive enable and bit 29 as the transmit enable. The new values are visible on the next cycle.
- R3: Read data always has bit 31 and bits 28:0 at zero, whatever data was written.
- R4: With the receive enable at 1, the interrupt is 1 on the cycle after `rx_full` is 1. With the receive enable at 0, the receive side contributes nothing.
- R5: With the transmit enable at 1, the interrupt is 1 on the cycle after `tx_full` is 0. With the transmit enable at 0, the transmit side contributes nothing.
- R6: The interrupt is the OR of the two side requests, registered once. It is 0 on the cycle after neither side requests.
- R7: `legacy_rx` equals `rx_full` and `legacy_tx` equals `tx_full` in every cycle, whatever the enable values.
- R8: An access with any field that does not match leaves both enables unchanged and reads as 0.
- R9: An access with `acc_el` equal to 0 (the unprivileged level) leaves both enables unchanged and reads as 0.
- R10: An access with `acc_allow` low leaves both enables unchanged and reads as 0.
- R11: A selected, granted read returns the receive enable in bit 30 and the transmit enable in bit 29, and leaves both enables unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | System-register access present this cycle |
| acc_write | input | 1 | 1 for a write, 0 for a read |
| acc_coproc | input | 4 | Coprocessor field of the encoding |
| acc_opc1 | input | 3 | First opcode field |
| acc_crn | input | 4 | Primary register field |
| acc_crm | input | 4 | Secondary register field |
| acc_opc2 | input | 3 | Second opcode field |
| acc_el | input | 2 | Privilege level of the access; 0 is unprivileged |
| acc_allow | input | 1 | Grant from the companion access checker |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data; 0 unless a selected, granted read |
| rx_full | input | 1 | Inbound mailbox holds a word |
| tx_full | input | 1 | Outbound mailbox is occupied |
| legacy_rx | output | 1 | Raw receive-full flag, passed through |
| legacy_tx | output | 1 | Raw transmit-full flag, passed through |
| dcc_irq | output | 1 | Combined, registered interrupt request |

## Verification
Several properties are checked on every cycle. The reserved read bits must be zero. Each side's request must show on the interrupt one cycle later, and the interrupt must drop when neither side requests. The enables must stay unchanged under an unprivileged access, a refused access, or any access that is not a granted write. The legacy lines must track the flags. Other behaviour only shows in the bench's scenarios against its reference model: the exact value a field mismatch reads back, the one-cycle delay from a write to its effect on the interrupt, and the opposite polarities of the two sides when flags and enables change together.

// File: rtl/dcc_irq_pkg.sv
package dcc_irq_pkg;
  localparam int unsigned REG_W   = 32;
  localparam int unsigned RX_POS  = 30;
  localparam int unsigned TX_POS  = 29;
  localparam int unsigned EL_W    = 2;

  localparam logic [3:0] ENC_COPROC = 4'b1110;
  localparam logic [2:0] ENC_OPC1   = 3'b000;
  localparam logic [3:0] ENC_CRN    = 4'b0000;
  localparam logic [3:0] ENC_CRM    = 4'b0010;
  localparam logic [2:0] ENC_OPC2   = 3'b000;

  typedef struct packed {
    logic [3:0] coproc;
    logic [2:0] opc1;
    logic [3:0] crn;
    logic [3:0] crm;
    logic [2:0] opc2;
  } sysreg_enc_t;

  typedef struct packed {
    logic rx;
    logic tx;
  } dcc_en_t;
endpackage

// File: rtl/dcc_acc_decode.sv
module dcc_acc_decode
  import dcc_irq_pkg::*;
#(
  parameter int unsigned ELW = EL_W,
  parameter sysreg_enc_t MATCH = '{coproc: ENC_COPROC, opc1: ENC_OPC1,
                                   crn: ENC_CRN, crm: ENC_CRM, opc2: ENC_OPC2}
) (
  input  logic           valid,
  input  logic           write,
  input  sysreg_enc_t    enc,
  input  logic [ELW-1:0] el,
  input  logic           allow,
  output logic           rd_hit,
  output logic           wr_hit
);
  localparam logic [ELW-1:0] EL_USER = '0;

  logic enc_ok;
  logic priv_ok;
  logic sel;

  always_comb begin
    enc_ok  = (enc == MATCH);
    priv_ok = (el != EL_USER);
    sel     = valid && enc_ok && priv_ok && allow;
    rd_hit  = sel && !write;
    wr_hit  = sel && write;
  end
endmodule

// File: rtl/dcc_en_reg.sv
module dcc_en_reg
  import dcc_irq_pkg::*;
#(
  parameter int unsigned W    = REG_W,
  parameter int unsigned RXB  = RX_POS,
  parameter int unsigned TXB  = TX_POS
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_hit,
  input  logic         rd_hit,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rdata,
  output dcc_en_t      en
);
  localparam logic [W-1:0] RW_MASK = (W'(1) << RXB) | (W'(1) << TXB);

  dcc_en_t en_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q <= '0;
    end else if (wr_hit) begin
      en_q.rx <= wdata[RXB];
      en_q.tx <= wdata[TXB];
    end
  end

  logic [W-1:0] view;
  always_comb begin
    view      = '0;
    view[RXB] = en_q.rx;
    view[TXB] = en_q.tx;
    rdata     = rd_hit ? view : '0;
    en        = en_q;
  end

  p_reserved_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rdata & ~RW_MASK) == '0);

  p_hold_no_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hit |=> $stable(en_q));
endmodule

// File: rtl/dcc_irq_gen.sv
module dcc_irq_gen
  import dcc_irq_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  dcc_en_t en,
  input  logic    rx_full,
  input  logic    tx_full,
  output logic    irq
);
  logic rx_req;
  logic tx_req;
  logic irq_q;

  always_comb begin
    rx_req = en.rx & rx_full;
    tx_req = en.tx & ~tx_full;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= rx_req | tx_req;
  end

  assign irq = irq_q;

  p_rx_side_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (en.rx && rx_full) |=> irq);

  p_tx_side_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (en.tx && !tx_full) |=> irq);

  p_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!(en.rx && rx_full) && !(en.tx && !tx_full)) |=> !irq);
endmodule

// File: rtl/dcc_irq_ctrl.sv
module dcc_irq_ctrl
  import dcc_irq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        acc_valid,
  input  logic        acc_write,
  input  logic [3:0]  acc_coproc,
  input  logic [2:0]  acc_opc1,
  input  logic [3:0]  acc_crn,
  input  logic [3:0]  acc_crm,
  input  logic [2:0]  acc_opc2,
  input  logic [1:0]  acc_el,
  input  logic        acc_allow,
  input  logic [31:0] acc_wdata,
  output logic [31:0] acc_rdata,
  input  logic        rx_full,
  input  logic        tx_full,
  output logic        legacy_rx,
  output logic        legacy_tx,
  output logic        dcc_irq
);
  sysreg_enc_t enc;
  logic        rd_hit;
  logic        wr_hit;
  dcc_en_t     en;

  assign enc = '{coproc: acc_coproc, opc1: acc_opc1, crn: acc_crn,
                 crm: acc_crm, opc2: acc_opc2};

  dcc_acc_decode #(.ELW(EL_W)) u_dec (
    .valid (acc_valid),
    .write (acc_write),
    .enc   (enc),
    .el    (acc_el),
    .allow (acc_allow),
    .rd_hit(rd_hit),
    .wr_hit(wr_hit)
  );

  dcc_en_reg #(.W(REG_W), .RXB(RX_POS), .TXB(TX_POS)) u_reg (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_hit(wr_hit),
    .rd_hit(rd_hit),
    .wdata (acc_wdata),
    .rdata (acc_rdata),
    .en    (en)
  );

  dcc_irq_gen u_irq (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (en),
    .rx_full(rx_full),
    .tx_full(tx_full),
    .irq    (dcc_irq)
  );

  assign legacy_rx = rx_full;
  assign legacy_tx = tx_full;

  p_user_blocked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_el == 2'd0) |=> $stable(en));

  p_refused_blocked_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_allow |=> $stable(en));

  p_enc_mismatch_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_crm != ENC_CRM) |-> (acc_rdata == '0));

  p_legacy_raw_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (legacy_rx == rx_full) && (legacy_tx == tx_full));
endmodule

// File: tb/test_dcc_irq_ctrl.sv
`timescale 1ns/1ps
module test_dcc_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 0, acc_write = 0, acc_allow = 0;
  logic [3:0]  acc_coproc = 0, acc_crn = 0, acc_crm = 0;
  logic [2:0]  acc_opc1 = 0, acc_opc2 = 0;
  logic [1:0]  acc_el = 0;
  logic [31:0] acc_wdata = 0;
  logic [31:0] acc_rdata;
  logic        rx_full = 0, tx_full = 1;
  logic        legacy_rx, legacy_tx, dcc_irq;

  always #2.5 clk = ~clk;

  dcc_irq_ctrl i_dcc_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_coproc(acc_coproc), .acc_opc1(acc_opc1), .acc_crn(acc_crn),
    .acc_crm(acc_crm), .acc_opc2(acc_opc2), .acc_el(acc_el),
    .acc_allow(acc_allow), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
    .rx_full(rx_full), .tx_full(tx_full), .legacy_rx(legacy_rx),
    .legacy_tx(legacy_tx), .dcc_irq(dcc_irq));

  // reference model
  bit m_rx, m_tx, m_irq;
  int vectors = 0, fails = 0;
  string tag = "R1";

  function automatic bit sel();
    return acc_valid && acc_coproc == 4'd14 && acc_opc1 == 3'd0 &&
           acc_crn == 4'd0 && acc_crm == 4'd2 && acc_opc2 == 3'd0 &&
           acc_el != 2'd0 && acc_allow;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_rx = 0; m_tx = 0; m_irq = 0;
    end else begin
      m_irq = (m_rx && rx_full) || (m_tx && !tx_full);
      if (sel() && acc_write) begin
        m_rx = acc_wdata[30];
        m_tx = acc_wdata[29];
      end
    end
  end

  task automatic compare();
    logic [31:0] exp_rd;
    exp_rd = (sel() && !acc_write) ? ({31'd0, m_rx} << 30) | ({31'd0, m_tx} << 29) : 32'd0;
    vectors++;
    if (dcc_irq !== m_irq) begin
      fails++; $display("FAIL %s irq act=%b exp=%b", tag, dcc_irq, m_irq);
    end
    if (acc_rdata !== exp_rd) begin
      fails++; $display("FAIL %s rdata act=%h exp=%h", tag, acc_rdata, exp_rd);
    end
    if (legacy_rx !== rx_full || legacy_tx !== tx_full) begin
      fails++; $display("FAIL %s legacy act=%b%b exp=%b%b", tag, legacy_rx, legacy_tx, rx_full, tx_full);
    end
  endtask

  task automatic vec(input bit v, input bit w, input logic [3:0] cp, input logic [2:0] o1,
                     input logic [3:0] cn, input logic [3:0] cm, input logic [2:0] o2,
                     input logic [1:0] el, input bit al, input logic [31:0] wd,
                     input bit rf, input bit tf);
    acc_valid = v; acc_write = w; acc_coproc = cp; acc_opc1 = o1; acc_crn = cn;
    acc_crm = cm; acc_opc2 = o2; acc_el = el; acc_allow = al; acc_wdata = wd;
    rx_full = rf; tx_full = tf;
    @(posedge clk);
    @(negedge clk);
    compare();
  endtask

  task automatic wr(input logic [31:0] d, input bit rf, input bit tf);
    vec(1, 1, 4'd14, 0, 0, 4'd2, 0, 2'd1, 1, d, rf, tf);
  endtask
  task automatic rd(input bit rf, input bit tf);
    vec(1, 0, 4'd14, 0, 0, 4'd2, 0, 2'd1, 1, 32'hFFFF_FFFF, rf, tf);
  endtask
  task automatic idle(input bit rf, input bit tf);
    vec(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, rf, tf);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog act=running exp=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    // R1: reset state
    tag = "R1";
    repeat (3) idle(1, 0);
    rst_n = 1'b1;
    rd(0, 1);
    rd(1, 0);
    // R7: legacy lines with enables off, all flag combos
    tag = "R7";
    for (int i = 0; i < 4; i++) idle(i[0], i[1]);
    // R2 / R3: write all ones, only two bits land
    tag = "R3";
    wr(32'hFFFF_FFFF, 0, 1);
    rd(0, 1);
    tag = "R2";
    wr(32'h4000_0000, 0, 1);
    rd(0, 1);
    wr(32'h2000_0000, 0, 1);
    rd(0, 1);
    // R4: receive side
    tag = "R4";
    wr(32'h4000_0000, 0, 1);
    for (int i = 0; i < 6; i++) idle(i[0], 1);
    wr(32'h0000_0000, 1, 1);
    idle(1, 1); idle(1, 1);
    // R5: transmit side fires on not-full
    tag = "R5";
    wr(32'h2000_0000, 0, 1);
    for (int i = 0; i < 6; i++) idle(0, i[1]);
    wr(32'h0000_0000, 0, 0);
    idle(0, 0); idle(0, 0);
    // R6: combined, all flag combos with both enables
    tag = "R6";
    wr(32'h6000_0000, 0, 1);
    for (int i = 0; i < 8; i++) idle(i[0], i[1]);
    // R7: legacy unaffected with both enables set
    tag = "R7";
    for (int i = 0; i < 4; i++) idle(i[1], i[0]);
    // R8: each field mismatched in turn
    tag = "R8";
    wr(32'h0000_0000, 0, 1);
    vec(1, 1, 4'd15, 0, 0, 4'd2, 0, 2'd1, 1, 32'h6000_0000, 0, 0);
    vec(1, 1, 4'd14, 3'd1, 0, 4'd2, 0, 2'd1, 1, 32'h6000_0000, 0, 0);
    vec(1, 1, 4'd14, 0, 4'd1, 4'd2, 0, 2'd1, 1, 32'h6000_0000, 0, 0);
    vec(1, 1, 4'd14, 0, 0, 4'd3, 0, 2'd1, 1, 32'h6000_0000, 0, 0);
    vec(1, 1, 4'd14, 0, 0, 4'd2, 3'd4, 2'd1, 1, 32'h6000_0000, 0, 0);
    vec(1, 0, 4'd14, 0, 0, 4'd0, 0, 2'd1, 1, 0, 0, 0);
    rd(1, 0);
    // R9: unprivileged access
    tag = "R9";
    vec(1, 1, 4'd14, 0, 0, 4'd2, 0, 2'd0, 1, 32'h6000_0000, 1, 0);
    vec(1, 0, 4'd14, 0, 0, 4'd2, 0, 2'd0, 1, 0, 1, 0);
    rd(1, 0);
    // R10: refused by checker
    tag = "R10";
    wr(32'h4000_0000, 1, 1);
    vec(1, 1, 4'd14, 0, 0, 4'd2, 0, 2'd3, 0, 32'h2000_0000, 1, 0);
    vec(1, 0, 4'd14, 0, 0, 4'd2, 0, 2'd2, 0, 0, 1, 0);
    rd(1, 0);
    // R11: repeated reads keep the value; other levels read too
    tag = "R11";
    for (int i = 0; i < 3; i++) rd(0, 0);
    vec(1, 0, 4'd14, 0, 0, 4'd2, 0, 2'd2, 1, 0, 0, 1);
    vec(1, 0, 4'd14, 0, 0, 4'd2, 0, 2'd3, 1, 0, 1, 1);
    // R1: reset again clears everything
    tag = "R1";
    wr(32'h6000_0000, 1, 0);
    rst_n = 1'b0;
    idle(1, 0); idle(1, 0);
    rst_n = 1'b1;
    rd(1, 0);
    idle(1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule